// File: doc/BRIEF.md
# Reset-Cause Dependent Strap Latch

This block reads a pair of interface-select strap pins once after each reset. It captures them as a 2-bit selection and derives a mode status bit from them. The moment of capture depends on which reset happened. A power-on reset, a low-voltage event or a clock-monitor failure opens a long window, about sixteen thousand reference-clock cycles after the reset ends. An external active-low reset opens a short window, a few tens of cycles after the pin is released. Before they are sampled, the strap pins pass through a two-stage synchronizer.

A single counter measures the time since the last reset event. The captured value is taken on the last cycle inside the selected window. From then on it is held, and a valid flag stays high until the next reset event. The status bit is 1 when the two captured pins match, whether both low or both high, and 0 when they differ.

The low-voltage and clock-monitor indications are single-cycle pulses that are synchronous to the clock. The external reset pin is assumed to be already synchronous to the clock. The power-on reset input also acts as the asynchronous reset of every flop in the block.

Top module: `strap_latch`

## Requirements
- R1: After the power-on reset input is released, `sel_valid` stays 0 for the first LONG_HI-1 rising clock edges and becomes 1 after edge LONG_HI (default 16410).
- R2: A one-cycle pulse on `lvr_evt` or `cmf_evt` restarts the long window. `sel_valid` becomes 1 after the LONG_HI-th rising edge that follows the edge which sampled the pulse.
- R3: While `ext_rst_n` is 0, `sel_valid` is 0. After release, `sel_valid` becomes 1 after the SHORT_HI-th rising edge (default 60), counted from the first edge that samples `ext_rst_n` high.
- R4: `sel_q` equals the value on `sel_pins` ahead of the edge two edges before `sel_valid` rises. This is the last window cycle, seen through the two-flop synchronizer. Values on the pins earlier in the window do not affect the result. Bit 0 of `sel_q` follows `sel_pins[0]`, and bit 1 follows `sel_pins[1]`.
- R5: `mode_eq` is 1 when `sel_q` is 00 or 11 and 0 when it is 01 or 10, once `sel_valid` is 1. `mode_eq` is 0 whenever `sel_valid` is 0.
- R6: Once `sel_valid` is 1, changes on `sel_pins` leave `sel_q`, `mode_eq` and `sel_valid` unchanged until the next reset event.
- R7: If an external reset occurs while a long window is still counting, the short window replaces it. `sel_valid` rises SHORT_HI edges after the external release.
- R8: Every reset event (power-on held, external pin low, or a low-voltage or clock-monitor pulse) clears `sel_valid`, `sel_q` and `mode_eq` to 0 on the next edge.
- R9: If the external reset pin is low in the same cycle as a long-reset pulse, the short window applies after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; also a long-window cause |
| lvr_evt | input | 1 | Low-voltage reset indication, one-cycle pulse |
| cmf_evt | input | 1 | Clock-monitor failure indication, one-cycle pulse |
| ext_rst_n | input | 1 | External reset pin, active low, synchronous |
| sel_pins | input | 2 | Interface-select strap pins, asynchronous |
| sel_q | output | 2 | Latched selection |
| mode_eq | output | 1 | 1 when both latched pins are equal |
| sel_valid | output | 1 | Selection captured and held |

## Verification
Two situations are hard to reach from the ports. The first is a long window that has not yet closed when an external reset arrives. The second is pins that change inside the window up to the cycle before the last one. The stimulus starts a long window with a low-voltage pulse, lets it run several hundred cycles, and then pulls the external pin low so that the short window must take over. In every window, the pins carry random values, then the complement of the final value, and switch to the final value only two synchronizer stages before capture. An early or late capture would therefore latch the wrong pair.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic {
    WIN_LONG  = 1'b0,
    WIN_SHORT = 1'b1
  } win_kind_e;

  // Status bit: set when both captured pins agree.
  function automatic logic pair_equal(input logic [1:0] pair);
    return ~(pair[1] ^ pair[0]);
  endfunction

  // Counter width that can hold the larger window end.
  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    int unsigned top;
    top = (a > b) ? a : b;
    return $clog2(top + 1);
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stage[g] <= '0;
          else        stage[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stage[g] <= '0;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage[STAGES-1];

endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer
  import strap_pkg::*;
#(
  parameter int unsigned LONG_LO  = 16380,
  parameter int unsigned LONG_HI  = 16410,
  parameter int unsigned SHORT_LO = 30,
  parameter int unsigned SHORT_HI = 60,
  parameter int unsigned CW       = 15
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_low,
  input  logic long_evt,
  output logic restart,
  output logic cap_fire
);

  localparam logic [CW-1:0] L_LO = CW'(LONG_LO);
  localparam logic [CW-1:0] L_HI = CW'(LONG_HI);
  localparam logic [CW-1:0] S_LO = CW'(SHORT_LO);
  localparam logic [CW-1:0] S_HI = CW'(SHORT_HI);

  win_kind_e     kind;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lo_sel;
  logic [CW-1:0] hi_sel;
  logic          win_open;
  logic          saturated;

  assign restart   = ext_low | long_evt;
  assign lo_sel    = (kind == WIN_SHORT) ? S_LO : L_LO;
  assign hi_sel    = (kind == WIN_SHORT) ? S_HI : L_HI;
  assign win_open  = (cnt >= lo_sel) && (cnt < hi_sel);
  assign saturated = (cnt == hi_sel);
  assign cap_fire  = !restart && (cnt == hi_sel - 1'b1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      kind <= WIN_LONG;
      cnt  <= '0;
    end else if (ext_low) begin
      kind <= WIN_SHORT;
      cnt  <= '0;
    end else if (long_evt) begin
      kind <= WIN_LONG;
      cnt  <= '0;
    end else if (!saturated) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r4_cap_in_window: assert property (@(posedge clk) disable iff (!por_n)
    cap_fire |-> win_open);

  a_r6_saturate: assert property (@(posedge clk) disable iff (!por_n)
    (saturated && !restart) |=> $stable(cnt) && !cap_fire);

  a_r9_ext_wins: assert property (@(posedge clk) disable iff (!por_n)
    ext_low |=> (kind == WIN_SHORT) && (cnt == '0));

  a_r2_long_restart: assert property (@(posedge clk) disable iff (!por_n)
    (long_evt && !ext_low) |=> (kind == WIN_LONG) && (cnt == '0));

endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       restart,
  input  logic       cap_fire,
  input  logic [1:0] sel_s,
  output logic [1:0] sel_q,
  output logic       mode_eq,
  output logic       sel_valid
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sel_q     <= 2'b00;
      mode_eq   <= 1'b0;
      sel_valid <= 1'b0;
    end else if (restart) begin
      sel_q     <= 2'b00;
      mode_eq   <= 1'b0;
      sel_valid <= 1'b0;
    end else if (cap_fire) begin
      sel_q     <= sel_s;
      mode_eq   <= pair_equal(sel_s);
      sel_valid <= 1'b1;
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!por_n)
    (sel_valid && !restart) |=> sel_valid && $stable(sel_q) && $stable(mode_eq));

  a_r8_clear: assert property (@(posedge clk) disable iff (!por_n)
    restart |=> !sel_valid && (sel_q == 2'b00) && !mode_eq);

  a_r5_idle_low: assert property (@(posedge clk) disable iff (!por_n)
    !sel_valid |-> !mode_eq);

  a_r5_eq_on_rise: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sel_valid) |-> (mode_eq == ($countones(sel_q) != 1)));

endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
#(
  parameter int unsigned LONG_LO  = 16380,
  parameter int unsigned LONG_HI  = 16410,
  parameter int unsigned SHORT_LO = 30,
  parameter int unsigned SHORT_HI = 60,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       lvr_evt,
  input  logic       cmf_evt,
  input  logic       ext_rst_n,
  input  logic [1:0] sel_pins,
  output logic [1:0] sel_q,
  output logic       mode_eq,
  output logic       sel_valid
);

  localparam int unsigned CW = cnt_width(LONG_HI, SHORT_HI);

  logic [1:0] sel_s;
  logic       restart;
  logic       cap_fire;
  logic       ext_low;
  logic       long_evt;

  assign ext_low  = ~ext_rst_n;
  assign long_evt = lvr_evt | cmf_evt;

  strap_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .por_n   (por_n),
    .d_async (sel_pins),
    .q_sync  (sel_s)
  );

  strap_window_timer #(
    .LONG_LO (LONG_LO),
    .LONG_HI (LONG_HI),
    .SHORT_LO(SHORT_LO),
    .SHORT_HI(SHORT_HI),
    .CW      (CW)
  ) u_timer (
    .clk     (clk),
    .por_n   (por_n),
    .ext_low (ext_low),
    .long_evt(long_evt),
    .restart (restart),
    .cap_fire(cap_fire)
  );

  strap_capture u_cap (
    .clk      (clk),
    .por_n    (por_n),
    .restart  (restart),
    .cap_fire (cap_fire),
    .sel_s    (sel_s),
    .sel_q    (sel_q),
    .mode_eq  (mode_eq),
    .sel_valid(sel_valid)
  );

  a_r3_ext_invalid: assert property (@(posedge clk) disable iff (!por_n)
    !ext_rst_n |=> !sel_valid);

endmodule

// File: tb/tb_strap_latch.sv
`timescale 1ns/1ps
module tb_strap_latch;

  localparam int unsigned LHI = 16410;
  localparam int unsigned SHI = 60;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       lvr_evt = 1'b0;
  logic       cmf_evt = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic [1:0] sel_pins = 2'b00;
  logic [1:0] sel_q;
  logic       mode_eq;
  logic       sel_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  strap_latch dut (
    .clk(clk), .por_n(por_n), .lvr_evt(lvr_evt), .cmf_evt(cmf_evt),
    .ext_rst_n(ext_rst_n), .sel_pins(sel_pins),
    .sel_q(sel_q), .mode_eq(mode_eq), .sel_valid(sel_valid)
  );

  function automatic logic exp_eq(input logic [1:0] p);
    return (p == 2'b00) || (p == 2'b11);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Entered at a negedge with the counter at zero; runs to capture and checks.
  task automatic run_window(input string req, input int unsigned hi, input logic [1:0] fin);
    for (int unsigned n = 1; n <= hi; n++) begin
      if (n >= hi - 2)       sel_pins = fin;
      else if (n == hi - 4 || n == hi - 3) sel_pins = ~fin;
      else                   sel_pins = 2'($urandom);
      step();
      if (n == hi - 1) chk({req, " valid before close"}, sel_valid, 0);
    end
    chk({req, " valid at close"}, sel_valid, 1);
    chk({req, " R4 captured pair"}, sel_q, fin);
    chk({req, " R5 mode_eq"}, mode_eq, exp_eq(fin));
  endtask

  task automatic hold_check(input int cycles);
    logic [1:0] q0;
    logic       e0;
    q0 = sel_q;
    e0 = mode_eq;
    for (int i = 0; i < cycles; i++) begin
      sel_pins = 2'($urandom);
      step();
    end
    chk("R6 sel_q held", sel_q, q0);
    chk("R6 mode_eq held", mode_eq, e0);
    chk("R6 valid held", sel_valid, 1);
  endtask

  task automatic pulse_long(input bit use_cmf);
    if (use_cmf) cmf_evt = 1'b1; else lvr_evt = 1'b1;
    step();
    cmf_evt = 1'b0;
    lvr_evt = 1'b0;
  endtask

  task automatic ext_pulse(input int low_cycles);
    ext_rst_n = 1'b0;
    for (int i = 0; i < low_cycles; i++) begin
      sel_pins = 2'($urandom);
      step();
      chk("R3 valid low while pin held", sel_valid, 0);
    end
    ext_rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    @(negedge clk);
    repeat (3) step();
    chk("R8 reset valid", sel_valid, 0);
    chk("R8 reset sel_q", sel_q, 0);
    chk("R8 reset mode_eq", mode_eq, 0);

    // R1: power-on release, long window
    por_n = 1'b1;
    run_window("R1 por", LHI, 2'b10);
    hold_check(40);

    // R8 and R2: clock-monitor pulse clears, long window restarts
    pulse_long(1'b1);
    chk("R8 clear valid", sel_valid, 0);
    chk("R8 clear sel_q", sel_q, 0);
    chk("R8 clear mode_eq", mode_eq, 0);
    run_window("R2 cmf", LHI, 2'b11);

    // R2: low-voltage pulse
    pulse_long(1'b0);
    run_window("R2 lvr", LHI, 2'b01);
    hold_check(25);

    // R3: external resets with random final pairs
    for (int k = 0; k < 8; k++) begin
      logic [1:0] f;
      f = 2'($urandom);
      if (k == 0) f = 2'b00;
      ext_pulse(1 + int'($urandom_range(0, 5)));
      run_window("R3 ext", SHI, f);
      hold_check(10);
    end

    // R7: external reset during a pending long window
    pulse_long(1'b0);
    for (int i = 0; i < 500; i++) begin
      sel_pins = 2'($urandom);
      step();
    end
    chk("R7 long still pending", sel_valid, 0);
    ext_pulse(3);
    run_window("R7 short replaces long", SHI, 2'b10);
    hold_check(100);

    // R9: pin low coincides with long pulse
    ext_rst_n = 1'b0;
    lvr_evt   = 1'b1;
    step();
    lvr_evt   = 1'b0;
    ext_rst_n = 1'b1;
    run_window("R9 ext priority", SHI, 2'b11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule